// File: doc/BRIEF.md
# Two-Phase Lookup Transmit Equalizer

This block sits in front of a segmented, resistance-modulated line driver in a half-rate serial transmitter. On every clock it receives two data bits: one for the even half-period and one for the odd half-period. For each half-period it builds a two-bit history pattern from the bit being sent now and the bit sent just before it. That pattern selects an entry in a small programmable table. The selected entry is a signed drive code that goes to the driver segments.

The two half-periods have separate tables. Software can therefore fold three corrections into the table contents: the driver's nonlinear transfer curve, two-tap channel pre-emphasis, and any duty-cycle or timing skew between the phases. The entries are not products worked out in hardware. They are arbitrary codes loaded through a one-entry-per-cycle write port.

Out of reset the tables give plain, non-equalized full-scale signalling. A typical program for a 0.75 main / −0.25 post-cursor target uses ±63 for a transition and ±31 for a repeated bit.

Top module: `txeq_lut_top`

## Requirements
- R1: While reset is asserted, both output codes are 7'h00. After reset, every table entry whose current-bit index is 1 holds 7'h3F and every entry whose current-bit index is 0 holds 7'h7F, whatever the history bit is.
- R2: The even-phase table index is {even bit, odd bit of the previous clock}, with bit 1 as the current bit. The history bit is 0 on the first clock after reset.
- R3: The odd-phase table index is {odd bit, even bit of the same clock}, with bit 1 as the current bit.
- R4: A code is sign-magnitude. Bit 6 is the sign (1 = negative) and bits 5:0 are the magnitude. Every stored 7-bit value, including 7'h40, reaches the output unchanged.
- R5: Both output codes are registered. The codes for the bit pair sampled at one rising edge appear after that edge.
- R6: A write with `wr_phase_i` = 0 loads the even table and a write with `wr_phase_i` = 1 loads the odd table, at entry `wr_addr_i`. The new value is used by lookups from the next clock onward.
- R7: A lookup in the same clock as a write to the entry it selects returns the entry's previous contents.
- R8: A write to one phase's table leaves the other phase's table unchanged.
- R9: Write data, address and phase have no effect while `wr_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_even_i | input | 1 | Data bit for the even half-period |
| bit_odd_i | input | 1 | Data bit for the odd half-period |
| wr_en_i | input | 1 | Table write strobe |
| wr_phase_i | input | 1 | Table select: 0 even, 1 odd |
| wr_addr_i | input | 2 | Entry index {current bit, previous bit} |
| wr_data_i | input | 7 | Sign-magnitude code to store |
| code_even_o | output | 7 | Registered drive code, even phase |
| code_odd_o | output | 7 | Registered drive code, odd phase |

## Verification
The case that is hardest to reach from the ports is a write that hits the very entry being looked up in the same clock. The data stream has to be steered so that the pattern equals the write address on that exact cycle. For the even phase, this also depends on the odd bit of the clock before. The bench first sends a pair that sets the history bit. It then writes the entry that the next pair will select while that pair is being sent, and repeats the pair to see the new value. The same stream is reused to write only the odd table. The even output is then checked for an unchanged value while the odd output shows negative zero.

// File: rtl/txeq_pkg.sv
package txeq_pkg;

  typedef enum logic {
    PH_EVEN = 1'b0,
    PH_ODD  = 1'b1
  } txeq_phase_e;

  // Table index: current bit in the upper position, history bit below it.
  function automatic logic [1:0] make_pattern(input logic cur_bit, input logic prev_bit);
    return {cur_bit, prev_bit};
  endfunction

endpackage

// File: rtl/txeq_pattern.sv
module txeq_pattern
  import txeq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_even_i,
  input  logic       bit_odd_i,
  output logic [1:0] pat_even_o,
  output logic [1:0] pat_odd_o
);

  // Last odd bit of the previous clock is the history for the next even bit.
  logic prev_odd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_odd_q <= 1'b0;
    else        prev_odd_q <= bit_odd_i;
  end

  always_comb begin
    pat_even_o = make_pattern(bit_even_i, prev_odd_q);
    pat_odd_o  = make_pattern(bit_odd_i, bit_even_i);
  end

endmodule

// File: rtl/txeq_lut_bank.sv
module txeq_lut_bank #(
  parameter int CODE_W = 7,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [CODE_W-1:0] wr_data_i,
  output logic [CODE_W-1:0] code_o
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int MAG_W   = CODE_W - 1;

  // Unequalized default: full-scale magnitude, sign taken from the current bit only.
  function automatic logic [CODE_W-1:0] default_code(input int unsigned idx);
    logic cur;
    cur = 1'((idx >> (IDX_W - 1)) & 1);
    return {~cur, {MAG_W{1'b1}}};
  endfunction

  logic [CODE_W-1:0] tbl_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) tbl_q[e] <= default_code(e);
    end else if (wr_en_i) begin
      tbl_q[wr_addr_i] <= wr_data_i;
    end
  end

  // Read sees the contents from before any write at this same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_o <= '0;
    else        code_o <= tbl_q[rd_idx_i];
  end

endmodule

// File: rtl/txeq_lut_top.sv
module txeq_lut_top
  import txeq_pkg::*;
#(
  parameter int MAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_even_i,
  input  logic             bit_odd_i,
  input  logic             wr_en_i,
  input  logic             wr_phase_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [MAG_W:0]   wr_data_i,
  output logic [MAG_W:0]   code_even_o,
  output logic [MAG_W:0]   code_odd_o
);

  localparam int CODE_W = MAG_W + 1;
  localparam int IDX_W  = 2;
  localparam int PHASES = 2;

  // Named internal events for the checker.
  logic [IDX_W-1:0]  pat_even_w;
  logic [IDX_W-1:0]  pat_odd_w;
  logic              wr_even_w;
  logic              wr_odd_w;

  logic [IDX_W-1:0]  pat_w  [PHASES];
  logic              wr_w   [PHASES];
  logic [CODE_W-1:0] code_w [PHASES];

  txeq_pattern u_pattern (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_even_i (bit_even_i),
    .bit_odd_i  (bit_odd_i),
    .pat_even_o (pat_even_w),
    .pat_odd_o  (pat_odd_w)
  );

  assign wr_even_w = wr_en_i && (txeq_phase_e'(wr_phase_i) == PH_EVEN);
  assign wr_odd_w  = wr_en_i && (txeq_phase_e'(wr_phase_i) == PH_ODD);

  assign pat_w[0] = pat_even_w;
  assign pat_w[1] = pat_odd_w;
  assign wr_w[0]  = wr_even_w;
  assign wr_w[1]  = wr_odd_w;

  for (genvar ph = 0; ph < PHASES; ph++) begin : g_bank
    txeq_lut_bank #(
      .CODE_W (CODE_W),
      .IDX_W  (IDX_W)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx_i  (pat_w[ph]),
      .wr_en_i   (wr_w[ph]),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .code_o    (code_w[ph])
    );
  end

  assign code_even_o = code_w[0];
  assign code_odd_o  = code_w[1];

endmodule

// File: rtl/txeq_lut_chk.sv
module txeq_lut_chk #(
  parameter int CODE_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_odd_i,
  input logic [1:0]        wr_addr_i,
  input logic [CODE_W-1:0] wr_data_i,
  input logic [1:0]        pat_even_w,
  input logic              wr_even_w,
  input logic              wr_odd_w,
  input logic [1:0]        pat_odd_w,
  input logic [CODE_W-1:0] code_even_o,
  input logic [CODE_W-1:0] code_odd_o
);

  logic [1:0] cyc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc_q <= '0;
    else if (cyc_q != 3) cyc_q <= cyc_q + 2'd1;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (code_even_o == '0 && code_odd_o == '0));

  p_even_history_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 2'd1) |-> (pat_even_w[0] == $past(bit_odd_i)));

  p_even_write_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_even_w ##1 (pat_even_w == $past(wr_addr_i))) |=> (code_even_o == $past(wr_data_i, 2)));

  p_odd_write_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_odd_w ##1 (pat_odd_w == $past(wr_addr_i))) |=> (code_odd_o == $past(wr_data_i, 2)));

  p_even_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 2'd2 && !$past(wr_even_w) && pat_even_w == $past(pat_even_w)) |=> $stable(code_even_o));

  p_odd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 2'd2 && !$past(wr_odd_w) && pat_odd_w == $past(pat_odd_w)) |=> $stable(code_odd_o));

endmodule

bind txeq_lut_top txeq_lut_chk #(.CODE_W(MAG_W + 1)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_odd_i   (bit_odd_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .pat_even_w  (pat_even_w),
  .wr_even_w   (wr_even_w),
  .wr_odd_w    (wr_odd_w),
  .pat_odd_w   (pat_odd_w),
  .code_even_o (code_even_o),
  .code_odd_o  (code_odd_o)
);

// File: tb/txeq_lut_top_tb_top.sv
module txeq_lut_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_even_i = 1'b0;
  logic       bit_odd_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       wr_phase_i = 1'b0;
  logic [1:0] wr_addr_i = 2'd0;
  logic [6:0] wr_data_i = 7'd0;
  logic [6:0] code_even_o;
  logic [6:0] code_odd_o;

  int checks = 0;
  int errors = 0;

  // Bench-side view of the tables and the even-phase history bit.
  logic [6:0] m_even [4];
  logic [6:0] m_odd  [4];
  logic       m_prev;

  // Stimulus pairs: bit 1 = even bit, bit 0 = odd bit.
  localparam logic [1:0] VEC [16] = '{
    2'b00, 2'b01, 2'b10, 2'b11, 2'b11, 2'b00, 2'b10, 2'b10,
    2'b01, 2'b01, 2'b11, 2'b10, 2'b00, 2'b00, 2'b01, 2'b11
  };

  always #5 clk = ~clk;

  txeq_lut_top dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_even_i  (bit_even_i),
    .bit_odd_i   (bit_odd_i),
    .wr_en_i     (wr_en_i),
    .wr_phase_i  (wr_phase_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .code_even_o (code_even_o),
    .code_odd_o  (code_odd_o)
  );

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: drive at a falling edge, look at the outputs one falling edge later.
  task automatic step(input logic e, input logic o, input logic we, input logic ph,
                      input logic [1:0] a, input logic [6:0] d, input string req);
    logic [6:0] exp_e, exp_o;
    bit_even_i = e;  bit_odd_i = o;
    wr_en_i = we;  wr_phase_i = ph;  wr_addr_i = a;  wr_data_i = d;
    exp_e = m_even[{e, m_prev}];
    exp_o = m_odd[{o, e}];
    @(negedge clk);
    check({req, " even"}, code_even_o, exp_e);
    check({req, " odd"},  code_odd_o,  exp_o);
    m_prev = o;
    if (we) begin
      if (ph) m_odd[a] = d;
      else    m_even[a] = d;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 defaults in the bench model.
    for (int i = 0; i < 4; i++) begin
      m_even[i] = (i >= 2) ? 7'h3F : 7'h7F;
      m_odd[i]  = (i >= 2) ? 7'h3F : 7'h7F;
    end
    m_prev = 1'b0;

    bit_even_i = 1'b1;  bit_odd_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset even", code_even_o, 7'h00);
    check("R1 reset odd",  code_odd_o,  7'h00);
    rst_n = 1'b1;

    // R1/R2: defaults after reset, history starts at 0.
    step(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 7'h00, "R1 R2 first");
    step(1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 7'h00, "R1 default");
    step(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 7'h00, "R1 default");

    // R9: strobe low, nothing written.
    step(1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 7'h11, "R9 idle even");
    step(1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 7'h22, "R9 idle odd");
    step(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 7'h00, "R9 entry2 kept");
    step(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 7'h00, "R9 entry0 kept");

    // R6: program a 0.75 / -0.25 target, odd table skewed for duty correction.
    step(1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 7'h5F, "R6 load");
    step(1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 7'h7F, "R6 load");
    step(1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 7'h3F, "R6 load");
    step(1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 7'h1F, "R6 load");
    step(1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 7'h5D, "R6 load");
    step(1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 7'h7E, "R6 load");
    step(1'b0, 1'b0, 1'b1, 1'b1, 2'd2, 7'h3E, "R6 load");
    step(1'b0, 1'b0, 1'b1, 1'b1, 2'd3, 7'h1D, "R6 load");

    // R2 R3 R5: walk the data pattern table.
    for (int v = 0; v < 16; v++)
      step(VEC[v][1], VEC[v][0], 1'b0, 1'b0, 2'd0, 7'h00, "R2 R3 R5 walk");

    // R7: write the entry being looked up in the same clock.
    step(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 7'h00, "R7 setup");
    step(1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 7'h2A, "R7 old value");
    step(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 7'h00, "R7 new value");

    // R8 and R4: odd-only write of negative zero; even unchanged.
    step(1'b1, 1'b1, 1'b1, 1'b1, 2'd3, 7'h40, "R8 write odd");
    step(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 7'h00, "R8 R4 isolate");
    step(1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 7'h00, "R8 R4 other");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule